// File: doc/BRIEF.md
# Bank Open-Row and Idle-Time Tracker

This block holds the per-bank state that a memory controller's scheduler consults and updates. It covers every bank of every rank. For each bank it keeps the open row, the time until which the bank is busy, and the time at which its minimum row-active interval ends. It also keeps a saturating byte counter and a saturating access counter for the current row. Beside the per-bank state it keeps the number of banks with a row open. For power accounting it also keeps the start of the current all-precharged window and a saturating total of the time during which every bank was precharged.

The scheduler issues one command per accepted handshake: open a row, do a column access, close a row by auto-precharge, replace the row after a miss, or do a closed-page access. The closed-page access is an activation followed at once by a forced close. Each close reports the bytes moved while the row was open as a one-cycle sample. A small state machine has three states. ST_READY accepts commands. ST_FORCE_PRE performs the forced close of a closed-page access. ST_REOPEN opens the new row after a miss. The transitions are READY to FORCE_PRE on a closed-page command, READY to REOPEN on a miss command, and both of those back to READY after one cycle. Every other accepted command stays in READY. A query port reads any bank's state.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset every bank holds the no-row value (all ones, 255 with 8-bit rows), its busy time, row-active-end time and both counters are zero, and the active count, idle start and idle total are zero.
- R2: An activate (op code 0) to bank index rank*BANKS_PER_RANK+bank loads the row and clears both counters. Its busy time becomes cmd_time. Its row-active-end time becomes cmd_time - tCL - tRCD + tRAS.
- R3: Every activation raises the active count by one and every close lowers it by one; the count never exceeds the total bank count.
- R4: On every close, sample_valid is high for the next cycle only, and sample_bytes carries the closed row's byte count. The bank's row returns to the no-row value and its busy time becomes the close-done time.
- R5: When a close leaves no bank open, the idle start becomes the larger of its previous value and the close-done time.
- R6: An activation with no bank open and an activation time (busy time minus tCL minus tRCD) strictly later than the idle start adds the difference to the idle total. In that case idle_valid pulses for one cycle. The idle total saturates at all ones.
- R7: An auto-precharge close (op code 2) finishes at the later of busy time and row-active-end time, plus tRP.
- R8: A miss command (op code 3) first closes the old row at the latest of busy time, row-active-end time and cur_time, plus tRP. In the next cycle it opens the new row as in R2 using the latched cmd_time. cmd_ready is low in between.
- R9: A closed-page command (op code 4) activates as in R2 but sets the byte count to one burst and the access count to 1. In the next cycle, with cmd_ready low, it closes the bank at the later of busy time and row-active-end time, plus tRP.
- R10: A column access (op code 1) adds cmd_bytes to the byte count and adds one to the access count, each saturating at all ones. It also sets the busy time to cmd_time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle (high in ST_READY) |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BANK_W | Flat bank index, rank-major |
| cmd_row | input | ROW_W | Row to open |
| cmd_time | input | TIME_W | Data-done time of the access |
| cmd_bytes | input | ADD_W | Bytes moved by a column access |
| cur_time | input | TIME_W | Present time from the controller |
| sample_valid | output | 1 | Bytes-per-activation sample strobe |
| sample_bytes | output | BYTE_W | Bytes-per-activation sample |
| idle_valid | output | 1 | Idle total was increased |
| idle_total | output | IDLE_W | Saturating all-precharged time |
| idle_start | output | TIME_W | Start of the all-precharged window |
| active_count | output | CNT_W | Banks with a row open |
| qry_bank | input | BANK_W | Bank to inspect |
| qry_row | output | ROW_W | Open row of that bank |
| qry_busy | output | TIME_W | Busy time of that bank |
| qry_tras | output | TIME_W | Row-active-end time of that bank |
| qry_bytes | output | BYTE_W | Byte count of that bank |
| qry_acc | output | ACC_W | Access count of that bank |

## Verification
The assertions assume that the scheduler sends only legal commands. An activate or closed-page command goes to a bank with no open row. A column, close or miss command goes to a bank with an open row. Every cmd_time is at least tCL plus tRCD, so the activation time does not wrap. The stimulus follows these rules by construction: it opens each bank before touching it, closes it before reopening it, and keeps all times small and positive. Under these assumptions, the active count stays between zero and the bank total, and the idle start and idle total never move backwards.

// File: rtl/bst_pkg.sv
package bst_pkg;
    typedef enum logic [2:0] {
        OP_ACT    = 3'd0,
        OP_COL    = 3'd1,
        OP_PRE    = 3'd2,
        OP_MISS   = 3'd3,
        OP_CLOSED = 3'd4
    } bst_op_e;

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_FORCE_PRE = 2'd1,
        ST_REOPEN    = 2'd2
    } bst_state_e;
endpackage

// File: rtl/bst_bank_file.sv
module bst_bank_file #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 8,
    parameter int TIME_W    = 16,
    parameter int BYTE_W    = 10,
    parameter int ACC_W     = 4,
    parameter int T_RAS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act,
    input  logic              wr_col,
    input  logic              wr_pre,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [TIME_W-1:0] wr_busy,
    input  logic [TIME_W-1:0] wr_act_time,
    input  logic [BYTE_W-1:0] wr_bytes,
    input  logic              wr_acc_one,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [TIME_W-1:0] rd_busy,
    output logic [TIME_W-1:0] rd_tras,
    output logic [BYTE_W-1:0] rd_bytes,
    input  logic [BANK_W-1:0] q_bank,
    output logic [ROW_W-1:0]  q_row,
    output logic [TIME_W-1:0] q_busy,
    output logic [TIME_W-1:0] q_tras,
    output logic [BYTE_W-1:0] q_bytes,
    output logic [ACC_W-1:0]  q_acc
);
    logic [ROW_W-1:0]  row_q   [NUM_BANKS];
    logic [TIME_W-1:0] busy_q  [NUM_BANKS];
    logic [TIME_W-1:0] tras_q  [NUM_BANKS];
    logic [BYTE_W-1:0] bytes_q [NUM_BANKS];
    logic [ACC_W-1:0]  acc_q   [NUM_BANKS];

    logic [BYTE_W:0] byte_sum;
    assign byte_sum = {1'b0, bytes_q[wr_bank]} + {1'b0, wr_bytes};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                row_q[i]   <= '1;
                busy_q[i]  <= '0;
                tras_q[i]  <= '0;
                bytes_q[i] <= '0;
                acc_q[i]   <= '0;
            end
        end else if (wr_act) begin
            row_q[wr_bank]   <= wr_row;
            busy_q[wr_bank]  <= wr_busy;
            tras_q[wr_bank]  <= wr_act_time + TIME_W'(T_RAS);
            bytes_q[wr_bank] <= wr_bytes;
            acc_q[wr_bank]   <= wr_acc_one ? ACC_W'(1) : '0;
        end else if (wr_col) begin
            busy_q[wr_bank]  <= wr_busy;
            bytes_q[wr_bank] <= byte_sum[BYTE_W] ? '1 : byte_sum[BYTE_W-1:0];
            if (acc_q[wr_bank] != '1) begin
                acc_q[wr_bank] <= acc_q[wr_bank] + ACC_W'(1);
            end
        end else if (wr_pre) begin
            row_q[wr_bank]  <= '1;
            busy_q[wr_bank] <= wr_busy;
        end
    end

    assign rd_busy  = busy_q[rd_bank];
    assign rd_tras  = tras_q[rd_bank];
    assign rd_bytes = bytes_q[rd_bank];
    assign q_row    = row_q[q_bank];
    assign q_busy   = busy_q[q_bank];
    assign q_tras   = tras_q[q_bank];
    assign q_bytes  = bytes_q[q_bank];
    assign q_acc    = acc_q[q_bank];
endmodule

// File: rtl/bst_idle_acct.sv
module bst_idle_acct #(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 4,
    parameter int TIME_W    = 16,
    parameter int IDLE_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_act,
    input  logic [TIME_W-1:0] act_time,
    input  logic              do_pre,
    input  logic [TIME_W-1:0] free_time,
    output logic [CNT_W-1:0]  active_count,
    output logic [TIME_W-1:0] idle_start,
    output logic [IDLE_W-1:0] idle_total,
    output logic              idle_valid
);
    localparam int SUM_W = ((TIME_W > IDLE_W) ? TIME_W : IDLE_W) + 1;
    localparam logic [SUM_W-1:0] IDLE_MAX = SUM_W'({IDLE_W{1'b1}});

    logic [SUM_W-1:0] idle_sum;
    assign idle_sum = SUM_W'(idle_total) + SUM_W'(act_time - idle_start);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_count <= '0;
            idle_start   <= '0;
            idle_total   <= '0;
            idle_valid   <= 1'b0;
        end else begin
            idle_valid <= 1'b0;
            if (do_act) begin
                if (active_count == '0 && act_time > idle_start) begin
                    idle_total <= (idle_sum > IDLE_MAX) ? '1 : idle_sum[IDLE_W-1:0];
                    idle_valid <= 1'b1;
                end
                if (active_count < CNT_W'(NUM_BANKS)) begin
                    active_count <= active_count + CNT_W'(1);
                end
            end else if (do_pre && active_count != '0) begin
                active_count <= active_count - CNT_W'(1);
                if (active_count == CNT_W'(1) && free_time > idle_start) begin
                    idle_start <= free_time;
                end
            end
        end
    end
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
    import bst_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 4,
    parameter int ROW_W          = 8,
    parameter int TIME_W         = 16,
    parameter int BYTE_W         = 10,
    parameter int ACC_W          = 4,
    parameter int IDLE_W         = 12,
    parameter int ADD_W          = 8,
    parameter int T_RCD          = 3,
    parameter int T_CL           = 3,
    parameter int T_RAS          = 8,
    parameter int T_RP           = 3,
    parameter int BURST_BYTES    = 32,
    localparam int NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK,
    localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CNT_W         = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [TIME_W-1:0] cmd_time,
    input  logic [ADD_W-1:0]  cmd_bytes,
    input  logic [TIME_W-1:0] cur_time,
    output logic              sample_valid,
    output logic [BYTE_W-1:0] sample_bytes,
    output logic              idle_valid,
    output logic [IDLE_W-1:0] idle_total,
    output logic [TIME_W-1:0] idle_start,
    output logic [CNT_W-1:0]  active_count,
    input  logic [BANK_W-1:0] qry_bank,
    output logic [ROW_W-1:0]  qry_row,
    output logic [TIME_W-1:0] qry_busy,
    output logic [TIME_W-1:0] qry_tras,
    output logic [BYTE_W-1:0] qry_bytes,
    output logic [ACC_W-1:0]  qry_acc
);
    localparam logic [TIME_W-1:0] ACT_LEAD = TIME_W'(T_RCD + T_CL);
    localparam logic [TIME_W-1:0] PRE_LEN  = TIME_W'(T_RP);

    bst_state_e        state_q, state_d;
    logic [BANK_W-1:0] lat_bank;
    logic [ROW_W-1:0]  lat_row;
    logic [TIME_W-1:0] lat_time;

    logic              do_act, do_col, do_pre, acc_one, accept;
    logic [BANK_W-1:0] wr_bank;
    logic [ROW_W-1:0]  wr_row;
    logic [TIME_W-1:0] wr_busy, act_time, pre_base;
    logic [BYTE_W-1:0] wr_bytes;
    logic [TIME_W-1:0] rd_busy, rd_tras;
    logic [BYTE_W-1:0] rd_bytes;

    assign act_time = wr_busy - ACT_LEAD;
    assign pre_base = (rd_busy > rd_tras) ? rd_busy : rd_tras;
    assign accept   = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_READY;
            lat_bank <= '0;
            lat_row  <= '0;
            lat_time <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lat_bank <= cmd_bank;
                lat_row  <= cmd_row;
                lat_time <= cmd_time;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cmd_ready = (state_q == ST_READY);
        do_act    = 1'b0;
        do_col    = 1'b0;
        do_pre    = 1'b0;
        acc_one   = 1'b0;
        wr_bank   = cmd_bank;
        wr_row    = cmd_row;
        wr_busy   = cmd_time;
        wr_bytes  = '0;
        unique case (state_q)
            ST_READY: begin
                if (cmd_valid) begin
                    unique case (bst_op_e'(cmd_op))
                        OP_ACT: do_act = 1'b1;
                        OP_COL: begin
                            do_col   = 1'b1;
                            wr_bytes = BYTE_W'(cmd_bytes);
                        end
                        OP_PRE: begin
                            do_pre  = 1'b1;
                            wr_busy = pre_base + PRE_LEN;
                        end
                        OP_MISS: begin
                            do_pre  = 1'b1;
                            wr_busy = ((pre_base > cur_time) ? pre_base : cur_time) + PRE_LEN;
                            state_d = ST_REOPEN;
                        end
                        OP_CLOSED: begin
                            do_act   = 1'b1;
                            acc_one  = 1'b1;
                            wr_bytes = BYTE_W'(BURST_BYTES);
                            state_d  = ST_FORCE_PRE;
                        end
                        default: ;
                    endcase
                end
            end
            ST_FORCE_PRE: begin
                wr_bank = lat_bank;
                do_pre  = 1'b1;
                wr_busy = pre_base + PRE_LEN;
                state_d = ST_READY;
            end
            ST_REOPEN: begin
                wr_bank = lat_bank;
                wr_row  = lat_row;
                wr_busy = lat_time;
                do_act  = 1'b1;
                state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            sample_bytes <= '0;
        end else begin
            sample_valid <= do_pre;
            if (do_pre) begin
                sample_bytes <= rd_bytes;
            end
        end
    end

    bst_bank_file #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .TIME_W(TIME_W),
        .BYTE_W(BYTE_W), .ACC_W(ACC_W), .T_RAS(T_RAS)
    ) banks_i (
        .clk(clk), .rst_n(rst_n),
        .wr_act(do_act), .wr_col(do_col), .wr_pre(do_pre),
        .wr_bank(wr_bank), .wr_row(wr_row), .wr_busy(wr_busy),
        .wr_act_time(act_time), .wr_bytes(wr_bytes), .wr_acc_one(acc_one),
        .rd_bank(wr_bank), .rd_busy(rd_busy), .rd_tras(rd_tras), .rd_bytes(rd_bytes),
        .q_bank(qry_bank), .q_row(qry_row), .q_busy(qry_busy), .q_tras(qry_tras),
        .q_bytes(qry_bytes), .q_acc(qry_acc)
    );

    bst_idle_acct #(
        .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .TIME_W(TIME_W), .IDLE_W(IDLE_W)
    ) idle_i (
        .clk(clk), .rst_n(rst_n),
        .do_act(do_act), .act_time(act_time),
        .do_pre(do_pre), .free_time(wr_busy),
        .active_count(active_count), .idle_start(idle_start),
        .idle_total(idle_total), .idle_valid(idle_valid)
    );
endmodule

// File: rtl/bst_chk.sv
module bst_chk
    import bst_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 4,
    parameter int TIME_W    = 16,
    parameter int IDLE_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [CNT_W-1:0]  active_count,
    input logic              sample_valid,
    input logic [IDLE_W-1:0] idle_total,
    input logic [TIME_W-1:0] idle_start
);
    logic take;
    assign take = cmd_valid && cmd_ready;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active_count <= CNT_W'(NUM_BANKS)); // R3

    AST_ACT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_ACT && active_count < CNT_W'(NUM_BANKS))
        |=> active_count == $past(active_count) + CNT_W'(1)); // R3

    AST_CLOSE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_PRE) |=> sample_valid); // R4

    AST_START_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> idle_start >= $past(idle_start)); // R5

    AST_IDLE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> idle_total >= $past(idle_total)); // R6

    AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_MISS) |=> !cmd_ready); // R8

    AST_CLOSED_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_CLOSED) |=> (!cmd_ready && sample_valid == 1'b0)); // R9
endmodule

bind bank_state_tracker bst_chk #(
    .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .TIME_W(TIME_W), .IDLE_W(IDLE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .active_count(active_count), .sample_valid(sample_valid),
    .idle_total(idle_total), .idle_start(idle_start)
);

// File: tb/bank_state_tracker_tb.sv
`timescale 1ns/1ps
module bank_state_tracker_tb_top;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_bank = '0;
    logic [7:0]  cmd_row = '0;
    logic [15:0] cmd_time = '0;
    logic [7:0]  cmd_bytes = '0;
    logic [15:0] cur_time = '0;
    logic        sample_valid, idle_valid;
    logic [9:0]  sample_bytes, qry_bytes;
    logic [11:0] idle_total;
    logic [15:0] idle_start, qry_busy, qry_tras;
    logic [3:0]  active_count, qry_acc;
    logic [2:0]  qry_bank = '0;
    logic [7:0]  qry_row;

    always #2.5 clk = ~clk;

    bank_state_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_time(cmd_time),
        .cmd_bytes(cmd_bytes), .cur_time(cur_time), .sample_valid(sample_valid),
        .sample_bytes(sample_bytes), .idle_valid(idle_valid), .idle_total(idle_total),
        .idle_start(idle_start), .active_count(active_count), .qry_bank(qry_bank),
        .qry_row(qry_row), .qry_busy(qry_busy), .qry_tras(qry_tras),
        .qry_bytes(qry_bytes), .qry_acc(qry_acc)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int m_row [NB];
    int m_busy [NB];
    int m_tras [NB];
    int m_bytes [NB];
    int m_acc [NB];
    int m_cnt, m_start, m_total;
    bit exp_sv, exp_iv;
    int exp_sb;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_act(input int b, input int t, input int row, input int bytes, input int acc);
        int at;
        at = t - 6;
        if (m_cnt == 0 && at > m_start) begin
            m_total = imin(m_total + at - m_start, 4095);
            exp_iv = 1'b1;
        end
        m_cnt++;
        m_row[b] = row; m_busy[b] = t; m_tras[b] = at + 8;
        m_bytes[b] = bytes; m_acc[b] = acc;
    endtask

    task automatic m_pre(input int b, input int free);
        exp_sv = 1'b1; exp_sb = m_bytes[b];
        m_row[b] = 255; m_busy[b] = free;
        m_cnt--;
        if (m_cnt == 0) m_start = imax(m_start, free);
    endtask

    task automatic check_all(input string tag, input bit exp_rdy);
        check(cmd_ready == exp_rdy, tag, int'(cmd_ready), int'(exp_rdy));
        check(int'(active_count) == m_cnt, "R3", int'(active_count), m_cnt);
        check(int'(idle_start) == m_start, "R5", int'(idle_start), m_start);
        check(int'(idle_total) == m_total, "R6", int'(idle_total), m_total);
        check(idle_valid == exp_iv, "R6", int'(idle_valid), int'(exp_iv));
        check(sample_valid == exp_sv, "R4", int'(sample_valid), int'(exp_sv));
        if (exp_sv) check(int'(sample_bytes) == exp_sb, "R4", int'(sample_bytes), exp_sb);
        for (int b = 0; b < NB; b++) begin
            qry_bank = 3'(b);
            #0.1;
            check(int'(qry_row) == m_row[b], tag, int'(qry_row), m_row[b]);
            check(int'(qry_busy) == m_busy[b], tag, int'(qry_busy), m_busy[b]);
            check(int'(qry_tras) == m_tras[b], tag, int'(qry_tras), m_tras[b]);
            check(int'(qry_bytes) == m_bytes[b], "R10", int'(qry_bytes), m_bytes[b]);
            check(int'(qry_acc) == m_acc[b], "R10", int'(qry_acc), m_acc[b]);
        end
    endtask

    task automatic step(input int op, input int b, input int row, input int t, input int n,
                        input int now, input string tag);
        int free;
        exp_sv = 1'b0; exp_iv = 1'b0;
        case (op)
            0: m_act(b, t, row, 0, 0);
            1: begin
                m_bytes[b] = imin(m_bytes[b] + n, 1023);
                m_acc[b] = imin(m_acc[b] + 1, 15);
                m_busy[b] = t;
            end
            2: m_pre(b, imax(m_busy[b], m_tras[b]) + 3);
            3: m_pre(b, imax(imax(m_busy[b], m_tras[b]), now) + 3);
            default: m_act(b, t, row, 32, 1);
        endcase
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_bank = 3'(b); cmd_row = 8'(row);
        cmd_time = 16'(t); cmd_bytes = 8'(n); cur_time = 16'(now);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        check_all(tag, !(op == 3 || op == 4));
        if (op == 3 || op == 4) begin
            exp_sv = 1'b0; exp_iv = 1'b0;
            if (op == 3) m_act(b, t, row, 0, 0);
            else begin
                free = imax(m_busy[b], m_tras[b]) + 3;
                m_pre(b, free);
            end
            @(posedge clk);
            @(negedge clk);
            check_all(tag, 1'b1);
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_row[b] = 255; m_busy[b] = 0; m_tras[b] = 0; m_bytes[b] = 0; m_acc[b] = 0;
        end
        m_cnt = 0; m_start = 0; m_total = 0; exp_sv = 0; exp_iv = 0; exp_sb = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b1);
        step(0, 0, 5, 20, 0, 0, "R2");          // open, idle gap 14
        for (int k = 0; k < 3; k++) step(1, 0, 0, 24, 64, 0, "R10");
        step(0, 5, 9, 30, 0, 0, "R2");          // second bank, no idle add
        step(2, 0, 0, 0, 0, 0, "R7");           // auto close at 27, sample 192
        step(3, 5, 12, 60, 0, 50, "R8");        // miss close at 53, reopen at 54
        step(2, 5, 0, 0, 0, 0, "R7");           // close at 65
        step(4, 3, 7, 100, 0, 0, "R9");         // closed page, forced close 105
        step(0, 7, 200, 110, 0, 0, "R2");       // activation before idle start
        for (int k = 0; k < 20; k++) step(1, 7, 0, 120, 64, 0, "R10");
        step(2, 7, 0, 0, 0, 0, "R4");           // saturated sample 1023
        step(0, 1, 3, 129, 0, 0, "R6");         // activation equal to idle start
        step(2, 1, 0, 0, 0, 0, "R5");
        step(0, 2, 4, 5000, 0, 0, "R6");        // idle total saturates
        step(3, 2, 6, 5100, 0, 4990, "R8");     // cur_time below other bounds
        step(2, 2, 0, 0, 0, 0, "R7");
        repeat (2) @(posedge clk);
        @(negedge clk);
        exp_sv = 1'b0; exp_iv = 1'b0;
        check_all("R4", 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule